// File: doc/BRIEF.md
# Input Sync Measurement Processor

This block watches the horizontal and vertical sync lines arriving from an input source. The lines are asynchronous to a free-running oscillator clock. Each line is brought into the oscillator domain, and any pulse too short to be a real sync edge is discarded. The cleaned level is made available to downstream logic.

For each line the block counts the oscillator cycles between consecutive rising edges of the cleaned sync. Firmware divides the oscillator frequency by that count to get the sync frequency. The block also raises a presence flag once the sync is fast enough. It drops the flag only when the sync becomes much slower, or disappears altogether. From the share of each period spent high and low it also infers the sync polarity.

Thresholds are given in hertz together with the oscillator frequency. The defaults are a 14.31818 MHz reference, presence set above 40 Hz and cleared below 10 Hz for the vertical line, and presence set above 10 kHz and cleared below 10 Hz for the horizontal line. The block converts these to cycle limits at elaboration time.

Top module: `sync_monitor`

## Requirements
- R1: Each sync input passes a two-flop synchronizer and then a filter that moves the clean level only after two consecutive synchronized samples agree on the new value. A pulse lasting one oscillator cycle never reaches the clean output, and the clean output never changes on two consecutive cycles.
- R2: The period output holds the number of oscillator cycles between the last two rising edges of the clean sync. The first rising edge after reset only starts the measurement and updates nothing.
- R3: Period, high-time and low-time counters saturate at 2^CNT_W-1. A period longer than that is reported as 2^CNT_W-1.
- R4: On a measured period strictly smaller than OSC_HZ/SET_HZ of that channel, the presence flag is set (1). A period equal to the limit does not set it.
- R5: The presence flag is cleared (0) when a measured period is strictly greater than OSC_HZ/CLR_HZ. It is also cleared, without waiting for an edge, once the running count since the last rising edge exceeds that limit. A period between the two limits leaves the flag unchanged.
- R6: Period, polarity and the set or clear decision on a measured period change only on a rising edge of the clean sync. The only change at another time is the timeout clear of R5.
- R7: The polarity flag is 1 (negative) when the clean sync was high for more cycles than it was low during the last measured period. It is 0 (positive) when high time is less than or equal to low time.
- R8: During and right after an active-low reset, all periods read 0 and all presence, polarity and clean outputs read 0.
- R9: The two channels are independent. Activity on one sync line leaves the other channel's period and polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| vsync_in | input | 1 | Raw vertical sync, asynchronous |
| h_clean | output | 1 | Synchronized, deglitched horizontal sync level |
| v_clean | output | 1 | Synchronized, deglitched vertical sync level |
| h_period | output | CNT_W | Horizontal period in oscillator cycles |
| v_period | output | CNT_W | Vertical period in oscillator cycles |
| h_present | output | 1 | Horizontal sync present |
| v_present | output | 1 | Vertical sync present |
| h_neg_pol | output | 1 | Horizontal sync negative polarity |
| v_neg_pol | output | 1 | Vertical sync negative polarity |

## Verification
The bench targets the exact threshold periods on both sides of each presence limit. A design that used the wrong comparison (≤ instead of <) would set or clear the flag at the limit itself. A sequence that crosses into the band between the limits checks the hysteresis: a design without it would lose or gain the flag there. A line held quiet past the clear limit must drop presence without a further edge, so a design that only decides on edges would keep a stale flag. Equal high and low times, periods beyond the counter range, and one-cycle glitches target, in turn, an inverted polarity tie-break, counters that wrap instead of saturating, and a filter that passes noise.

// File: rtl/sync_meas_pkg.sv
// Package: shared constants and helpers for the sync measurement block.
// Assumes frequencies are given as positive integers in hertz.
package sync_meas_pkg;

    localparam int NUM_CH = 2;
    localparam int CH_H   = 0;
    localparam int CH_V   = 1;

    // Converts a frequency threshold into a period limit in oscillator cycles.
    function automatic int period_limit(input int osc_hz, input int thr_hz);
        return osc_hz / thr_hz;
    endfunction

endpackage

// File: rtl/sync_deglitch.sv
// Module: sync_deglitch
// Brings one asynchronous sync line into the clock domain through two flops.
// It then accepts a new level only when two consecutive synchronized samples
// agree, so a single-cycle pulse is dropped.
// Assumes clk is the free-running oscillator; reset is synchronous, active low.
module sync_deglitch (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_o
);

    logic meta_q;
    logic sync_q;
    logic hist_q;
    logic clean_q;

    // Synchronizer chain plus one history stage for the stability check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    // Clean level follows the synchronized level once two samples agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_q <= 1'b0;
        end else if (sync_q == hist_q) begin
            clean_q <= sync_q;
        end
    end

    assign clean_o = clean_q;

endmodule

// File: rtl/sync_period_meter.sv
// Module: sync_period_meter
// Measures one clean sync line: period between rising edges, high and low
// time inside that period, presence with separate set/clear limits, and
// polarity from the duty cycle. All counters saturate.
// Assumes CLR_LIM < 2^CNT_W-1 and SET_LIM <= CLR_LIM.
module sync_period_meter #(
    parameter int CNT_W   = 22,
    parameter int SET_LIM = 357954,
    parameter int CLR_LIM = 1431818
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clean_in,
    output logic [CNT_W-1:0] period_o,
    output logic             present_o,
    output logic             neg_pol_o
);

    localparam logic [CNT_W-1:0] MAX_V = '1;
    localparam logic [CNT_W-1:0] SET_V = CNT_W'(SET_LIM);
    localparam logic [CNT_W-1:0] CLR_V = CNT_W'(CLR_LIM);

    logic             prev_q;
    logic             primed_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] per_q;
    logic             pres_q;
    logic             neg_q;
    logic             rise;
    logic [CNT_W-1:0] per_meas;

    // Increments a count unless it already sits at full scale.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == MAX_V) ? v : v + 1'b1;
    endfunction

    assign rise     = clean_in & ~prev_q;
    assign per_meas = sat_inc(run_q);

    // Previous clean level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= clean_in;
    end

    // Running period, high and low counters restarted on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
        end else if (rise) begin
            run_q <= '0;
            hi_q  <= CNT_W'(1);
            lo_q  <= '0;
        end else begin
            run_q <= sat_inc(run_q);
            if (clean_in) hi_q <= sat_inc(hi_q);
            else          lo_q <= sat_inc(lo_q);
        end
    end

    // Period and polarity results latched at each measured rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            per_q    <= '0;
            neg_q    <= 1'b0;
        end else if (rise) begin
            primed_q <= 1'b1;
            if (primed_q) begin
                per_q <= per_meas;
                neg_q <= (hi_q > lo_q);
            end
        end
    end

    // Presence flag with hysteresis and a timeout clear for a missing sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pres_q <= 1'b0;
        end else if (rise && primed_q) begin
            if (per_meas < SET_V)      pres_q <= 1'b1;
            else if (per_meas > CLR_V) pres_q <= 1'b0;
        end else if (!rise && (run_q >= CLR_V)) begin
            pres_q <= 1'b0;
        end
    end

    assign period_o  = per_q;
    assign present_o = pres_q;
    assign neg_pol_o = neg_q;

endmodule

// File: rtl/sync_monitor.sv
// Module: sync_monitor (top)
// Measures the horizontal and vertical sync lines in the oscillator domain.
// One deglitch stage and one period meter are built per channel. Limits are
// derived from the oscillator frequency and the threshold frequencies.
// Assumes sync inputs are asynchronous and every real phase lasts >= 2 cycles.
module sync_monitor #(
    parameter int OSC_HZ   = 14318180,
    parameter int CNT_W    = 22,
    parameter int H_SET_HZ = 10000,
    parameter int H_CLR_HZ = 10,
    parameter int V_SET_HZ = 40,
    parameter int V_CLR_HZ = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    output logic             h_clean,
    output logic             v_clean,
    output logic [CNT_W-1:0] h_period,
    output logic [CNT_W-1:0] v_period,
    output logic             h_present,
    output logic             v_present,
    output logic             h_neg_pol,
    output logic             v_neg_pol
);

    import sync_meas_pkg::*;

    localparam int H_SET_LIM = period_limit(OSC_HZ, H_SET_HZ);
    localparam int H_CLR_LIM = period_limit(OSC_HZ, H_CLR_HZ);
    localparam int V_SET_LIM = period_limit(OSC_HZ, V_SET_HZ);
    localparam int V_CLR_LIM = period_limit(OSC_HZ, V_CLR_HZ);

    logic [NUM_CH-1:0] raw_w;
    logic [NUM_CH-1:0] clean_w;
    logic [NUM_CH-1:0] pres_w;
    logic [NUM_CH-1:0] neg_w;
    logic [CNT_W-1:0]  per_w [NUM_CH];

    assign raw_w[CH_H] = hsync_in;
    assign raw_w[CH_V] = vsync_in;

    // One measurement channel per sync line.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int SET_L = (g == CH_H) ? H_SET_LIM : V_SET_LIM;
        localparam int CLR_L = (g == CH_H) ? H_CLR_LIM : V_CLR_LIM;

        sync_deglitch u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (raw_w[g]),
            .clean_o (clean_w[g])
        );

        sync_period_meter #(
            .CNT_W   (CNT_W),
            .SET_LIM (SET_L),
            .CLR_LIM (CLR_L)
        ) u_pm (
            .clk       (clk),
            .rst_n     (rst_n),
            .clean_in  (clean_w[g]),
            .period_o  (per_w[g]),
            .present_o (pres_w[g]),
            .neg_pol_o (neg_w[g])
        );
    end

    assign h_clean   = clean_w[CH_H];
    assign v_clean   = clean_w[CH_V];
    assign h_period  = per_w[CH_H];
    assign v_period  = per_w[CH_V];
    assign h_present = pres_w[CH_H];
    assign v_present = pres_w[CH_V];
    assign h_neg_pol = neg_w[CH_H];
    assign v_neg_pol = neg_w[CH_V];

endmodule

// File: rtl/sync_monitor_sva.sv
// Module: sync_monitor_sva
// Checker bound to sync_monitor; observes only its ports.
module sync_monitor_sva #(
    parameter int CNT_W = 22,
    parameter int H_SET = 1431,
    parameter int H_CLR = 1431818,
    parameter int V_SET = 357954,
    parameter int V_CLR = 1431818
) (
    input logic             clk,
    input logic             rst_n,
    input logic             h_clean,
    input logic             v_clean,
    input logic [CNT_W-1:0] h_period,
    input logic [CNT_W-1:0] v_period,
    input logic             h_present,
    input logic             v_present,
    input logic             h_neg_pol,
    input logic             v_neg_pol
);

    AST_H_CLEAN_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(h_clean) |=> $stable(h_clean)); // R1
    AST_V_CLEAN_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v_clean) |=> $stable(v_clean)); // R1
    AST_H_PERIOD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(h_clean) |=> $stable(h_period)); // R6
    AST_V_PERIOD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(v_clean) |=> $stable(v_period)); // R6
    AST_H_POL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(h_clean) |=> $stable(h_neg_pol)); // R7
    AST_V_POL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(v_clean) |=> $stable(v_neg_pol)); // R7
    AST_H_SET_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_present) |-> (int'(h_period) < H_SET)); // R4
    AST_V_SET_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_present) |-> (int'(v_period) < V_SET)); // R4
    AST_H_NO_SLOW_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        h_present |-> (int'(h_period) <= H_CLR)); // R5
    AST_V_NO_SLOW_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        v_present |-> (int'(v_period) <= V_CLR)); // R5

endmodule

bind sync_monitor sync_monitor_sva #(
    .CNT_W (CNT_W),
    .H_SET (H_SET_LIM),
    .H_CLR (H_CLR_LIM),
    .V_SET (V_SET_LIM),
    .V_CLR (V_CLR_LIM)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_clean   (h_clean),
    .v_clean   (v_clean),
    .h_period  (h_period),
    .v_period  (v_period),
    .h_present (h_present),
    .v_present (v_present),
    .h_neg_pol (h_neg_pol),
    .v_neg_pol (v_neg_pol)
);

// File: tb/sync_monitor_tb.sv
// Bench for sync_monitor: directed threshold cases plus seeded random bursts,
// checked against a waveform model built from the driven edge times.
module sync_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OSC        = 100000;
    localparam int CW         = 9;
    localparam int HSET_HZ    = 5000;
    localparam int HCLR_HZ    = 1000;
    localparam int VSET_HZ    = 1000;
    localparam int VCLR_HZ    = 250;
    localparam int MAXV       = (1 << CW) - 1;
    localparam int W          = 8;
    localparam int SETL [2]   = '{OSC / HSET_HZ, OSC / VSET_HZ};
    localparam int CLRL [2]   = '{OSC / HCLR_HZ, OSC / VCLR_HZ};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0;
    logic vs = 1'b0;
    logic          h_clean, v_clean, h_present, v_present, h_neg_pol, v_neg_pol;
    logic [CW-1:0] h_period, v_period;

    sync_monitor #(
        .OSC_HZ(OSC), .CNT_W(CW), .H_SET_HZ(HSET_HZ), .H_CLR_HZ(HCLR_HZ),
        .V_SET_HZ(VSET_HZ), .V_CLR_HZ(VCLR_HZ)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
        .h_clean(h_clean), .v_clean(v_clean), .h_period(h_period), .v_period(v_period),
        .h_present(h_present), .v_present(v_present),
        .h_neg_pol(h_neg_pol), .v_neg_pol(v_neg_pol)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    int e_per [2] = '{0, 0};
    int e_neg [2] = '{0, 0};
    int e_pres [2] = '{0, 0};
    int primed [2] = '{0, 0};
    int lvl [2] = '{0, 0};
    int t_rise [2] = '{0, 0};
    int t_fall [2] = '{0, 0};

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    function automatic int get_per(input int ch);
        return (ch == 0) ? int'(h_period) : int'(v_period);
    endfunction
    function automatic int get_pres(input int ch);
        return (ch == 0) ? int'(h_present) : int'(v_present);
    endfunction
    function automatic int get_neg(input int ch);
        return (ch == 0) ? int'(h_neg_pol) : int'(v_neg_pol);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives a line and updates the expected results on each rising edge.
    task automatic drive(input int ch, input int v);
        if (v == 1 && lvl[ch] == 0) begin
            if (primed[ch] != 0) begin
                int per;
                int hi;
                int lo;
                per = sat(cyc - t_rise[ch]);
                hi  = sat(t_fall[ch] - t_rise[ch]);
                lo  = sat(cyc - t_fall[ch]);
                e_per[ch] = per;
                e_neg[ch] = (hi > lo) ? 1 : 0;
                if (per < SETL[ch])      e_pres[ch] = 1;
                else if (per > CLRL[ch]) e_pres[ch] = 0;
            end
            primed[ch] = 1;
            t_rise[ch] = cyc;
        end else if (v == 0 && lvl[ch] == 1) begin
            t_fall[ch] = cyc;
        end
        lvl[ch] = v;
        if (ch == 0) hs = v[0];
        else         vs = v[0];
    endtask

    task automatic check_ch(input int ch, input string tag);
        check({tag, " period"},   get_per(ch),  e_per[ch]);
        check({tag, " polarity"}, get_neg(ch),  e_neg[ch]);
        check({tag, " presence"}, get_pres(ch), e_pres[ch]);
    endtask

    // k periods of H high / L low, then a closing rising edge and W idle cycles.
    task automatic burst(input int ch, input int h, input int l, input int k, input string tag);
        int other;
        int o_per;
        int o_neg;
        other = 1 - ch;
        o_per = get_per(other);
        o_neg = get_neg(other);
        drive(ch, 0);
        tick(l);
        for (int i = 0; i < k; i++) begin
            drive(ch, 1);
            tick(h);
            drive(ch, 0);
            tick(l);
        end
        drive(ch, 1);
        tick(W);
        check_ch(ch, tag);
        check("R9 other period", get_per(other), o_per);
        check("R9 other polarity", get_neg(other), o_neg);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        int highs;
        seed_v = $urandom(32'd4242);
        tick(5);
        // R8 reset state
        check("R8 h_period", int'(h_period), 0);
        check("R8 v_period", int'(v_period), 0);
        check("R8 flags", int'({h_present, v_present, h_neg_pol, v_neg_pol, h_clean, v_clean}), 0);
        rst_n = 1'b1;
        tick(3);
        check("R8 after release", int'({h_present, v_present, h_period, v_period}), 0);

        // R2 R4 fast vertical sync; R7 equal halves give positive polarity
        burst(1, 20, 20, 3, "R2 R4 R7 v fast");
        // R5 R6 timeout clear with no edge, period held
        tick(420);
        check("R5 timeout v_present", int'(v_present), 0);
        check("R6 v_period held", int'(v_period), 40);
        e_pres[1] = 0;
        // R4 period equal to set limit does not set
        burst(1, 8, 92, 2, "R4 at set limit");
        burst(1, 50, 49, 2, "R4 R7 below set limit");
        // R5 hysteresis: at clear limit holds, above clears, band holds zero
        burst(1, 200, 200, 2, "R5 at clear limit");
        burst(1, 201, 200, 2, "R5 above clear limit");
        burst(1, 150, 150, 2, "R5 band holds cleared");
        // R3 saturation of period and of high/low counters
        burst(1, 30, 600, 2, "R3 saturate low");
        burst(1, 600, 30, 2, "R3 R7 saturate high");
        // Horizontal channel thresholds, R9 on vertical
        burst(0, 5, 5, 3, "R4 R9 h fast");
        burst(0, 3, 16, 2, "R4 h below set");
        burst(0, 10, 10, 2, "R5 h at set limit holds");
        burst(0, 60, 45, 2, "R5 R7 h above clear");

        // Seeded random bursts
        for (int i = 0; i < 12; i++) begin
            int ch;
            int h;
            int l;
            int k;
            ch = int'($urandom % 2);
            h  = 2 + int'($urandom % 260);
            l  = 2 + int'($urandom % 260);
            if ($urandom % 4 == 0) l = l + 300;
            k  = 2 + int'($urandom % 2);
            burst(ch, h, l, k, "R2 R7 random");
        end

        // R1 single-cycle glitch is rejected, two-cycle pulse passes
        drive(0, 0);
        tick(12);
        hs = 1'b1;
        tick(1);
        hs = 1'b0;
        highs = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (h_clean) highs++;
        end
        check("R1 glitch rejected", highs, 0);
        hs = 1'b1;
        tick(1);
        highs = 0;
        if (h_clean) highs++;
        tick(1);
        hs = 1'b0;
        if (h_clean) highs++;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (h_clean) highs++;
        end
        check("R1 two-cycle pulse width", highs, 2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule